// File: doc/BRIEF.md
# DRAM Command Issue-Time Gate

This block tells a memory controller's scheduler the first clock cycle in which a candidate command may be put on the DRAM command bus without breaking any device timing rule. The scheduler presents a command type and its target location (rank, bank group within the rank, bank within the group) on the query inputs. The block answers within the same cycle, through combinational logic, with an absolute earliest cycle and with the distance from the current cycle. A free-running cycle counter is exposed so that the caller and the answer share one time base.

The history is kept at four levels of scope: one bank, one bank group, one rank, and the whole device. Each time a command really goes on the bus, the scheduler pulses the record strobe with that command and its target. Refresh commands are included. The record port is a plain strobe with no ready signal. It accepts every pulse, at most one per cycle, and never applies back-pressure. Each stored timestamp has a valid bit, so a rule only applies once the command it refers to has been recorded. A per-rank history of the last activates enforces the rolling four-activate window.

All timings are parameters in clock cycles. The defaults are tRC 12, tRP 4, tRTP 3, tWL 4, tRL 6, burst length 8, tWR 5, tRRD_L 4, tRRD_S 2, tRFC 20, tFAW 16, tRCD 4, tCCD_L 4, tCCD_S 2, tWTR_L 5, tWTR_S 2 and tRAS 9. The default geometry is 2 ranks, 2 groups per rank and 2 banks per group. A data burst lasts BL/2 clocks.

Top module: `ddr_cmd_gate`

## Requirements
- R1: Command codes are 0 ACT, 1 RD, 2 RDA, 3 WR, 4 WRA, 5 PRE, 6 all-bank refresh, 7 per-bank refresh. `now_cycle` is 0 in reset and rises by one each clock. `earliest_cycle` is never below `now_cycle`, and `wait_cycles` equals `earliest_cycle - now_cycle`. Every command also waits one clock after the last recorded command of any kind.
- R2: An ACT waits tRC after an ACT to the same bank, tRP after a PRE to it, tRTP+tRP after an RDA to it, and tWL+BL/2+tWR+tRP after a WRA to it.
- R3: An ACT waits tRRD_L after an ACT in the same bank group and tRRD_S after an ACT anywhere in the same rank. ACTs in another rank impose nothing beyond R1.
- R4: An ACT waits tRFC after an all-bank refresh of its rank and tRFC after a per-bank refresh of its own bank.
- R5: Once a rank has recorded four or more ACTs, a new ACT to it waits until the oldest of its last four ACT cycles plus tFAW. Ranks do not share this history.
- R6: RD and RDA wait tRCD after the same bank's ACT, tCCD_L after an RD or RDA in the same group, and tCCD_S after an RD or RDA anywhere.
- R7: RD and RDA wait tWL+BL/2+tWTR_L after a WR or WRA in the same group and tWL+BL/2+tWTR_S after a WR or WRA anywhere.
- R8: WR and WRA wait tRCD after the same bank's ACT, tRL+BL/2+2-tWL after an RD or RDA anywhere, tCCD_L after a WR or WRA in the same group, and tCCD_S after a WR or WRA anywhere.
- R9: PRE waits tRAS after the same bank's ACT, tRTP after an RD to that bank, and tWL+BL/2+tWR after a WR to that bank.
- R10: Reset clears every valid bit. After reset, and for kinds never recorded, no rule applies and `earliest_cycle` equals `now_cycle`.
- R11: A record pulse does not affect the answer given in the same cycle. It is reflected from the following cycle on, with the timestamp equal to the `now_cycle` value of the cycle in which it was pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_cmd | input | 3 | Candidate command code |
| q_rank | input | RW | Candidate rank |
| q_group | input | GW | Candidate bank group within rank |
| q_bank | input | BW | Candidate bank within group |
| rec_valid | input | 1 | A command issues this cycle |
| rec_cmd | input | 3 | Code of the issuing command |
| rec_rank | input | RW | Rank of the issuing command |
| rec_group | input | GW | Bank group of the issuing command |
| rec_bank | input | BW | Bank of the issuing command |
| now_cycle | output | CW | Free-running cycle count |
| earliest_cycle | output | CW | First legal issue cycle for the candidate |
| wait_cycles | output | CW | Cycles from now until that cycle |

## Verification
A record pulse and a query can fall in the same cycle, and they can target the same bank. That is the normal case for a scheduler that records one command while it evaluates the next. The bench provokes this by driving an ACT record and an ACT query to one bank in a single cycle. Within that cycle the answer must still equal the current cycle, because the old history applies. One clock later the answer must jump to the recorded cycle plus tRC. A design that forwards the record into the same-cycle answer fails the first check. A design that drops or delays the record fails the second.

// File: rtl/ddr_gate_pkg.sv
`timescale 1ns/1ps
package ddr_gate_pkg;

  typedef enum logic [2:0] {
    CMD_ACT  = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDA  = 3'd2,
    CMD_WR   = 3'd3,
    CMD_WRA  = 3'd4,
    CMD_PRE  = 3'd5,
    CMD_REFA = 3'd6,
    CMD_REFB = 3'd7
  } gate_cmd_e;

  // One-hot masks over the eight codes; a history slot captures any code in its mask
  localparam logic [7:0] MSK_ACT  = 8'h01;
  localparam logic [7:0] MSK_RD   = 8'h02;
  localparam logic [7:0] MSK_RDA  = 8'h04;
  localparam logic [7:0] MSK_WR   = 8'h08;
  localparam logic [7:0] MSK_WRA  = 8'h10;
  localparam logic [7:0] MSK_PRE  = 8'h20;
  localparam logic [7:0] MSK_REFA = 8'h40;
  localparam logic [7:0] MSK_REFB = 8'h80;
  localparam logic [7:0] MSK_RDX  = 8'h06;
  localparam logic [7:0] MSK_WRX  = 8'h18;
  localparam logic [7:0] MSK_ANY  = 8'hFF;

endpackage

// File: rtl/gate_hist_level.sv
`timescale 1ns/1ps
// One scope level of issue history: N_KIND command classes x N_ENT locations
module gate_hist_level #(
  parameter int CW = 32,
  parameter int N_ENT = 1,
  parameter int N_KIND = 1,
  parameter int IW = 1,
  parameter logic [N_KIND*8-1:0] MASKS = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rec_valid,
  input  logic [2:0]                 rec_cmd,
  input  logic [IW-1:0]              rec_idx,
  input  logic [CW-1:0]              now,
  output logic [N_KIND*N_ENT*CW-1:0] stamps,
  output logic [N_KIND*N_ENT-1:0]    vlds
);

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic          v;
      logic [CW-1:0] s;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v <= 1'b0;
          s <= '0;
        end else if (rec_valid && MASKS[k*8 + int'(rec_cmd)] && rec_idx == IW'(e)) begin
          v <= 1'b1;
          s <= now;
        end
      end

      assign vlds[k*N_ENT + e]               = v;
      assign stamps[(k*N_ENT + e)*CW +: CW]  = s;

      // R11
      stamp_past_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v |-> (s < now));
    end
  end

endmodule

// File: rtl/gate_act_window.sv
`timescale 1ns/1ps
// Per-rank record of the most recent DEPTH activate cycles
module gate_act_window #(
  parameter int CW = 32,
  parameter int N_RANK = 2,
  parameter int DEPTH = 4,
  parameter int RW = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rec_act,
  input  logic [RW-1:0]        rec_rank,
  input  logic [CW-1:0]        now,
  output logic [N_RANK*CW-1:0] oldest,
  output logic [N_RANK-1:0]    full
);

  localparam int NW = $clog2(DEPTH + 1);

  for (genvar r = 0; r < N_RANK; r++) begin : g_rank
    logic [CW-1:0] win [DEPTH];
    logic [NW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        for (int j = 0; j < DEPTH; j++) win[j] <= '0;
      end else if (rec_act && rec_rank == RW'(r)) begin
        win[0] <= now;
        for (int j = 1; j < DEPTH; j++) win[j] <= win[j-1];
        if (cnt != NW'(DEPTH)) cnt <= cnt + 1'b1;
      end
    end

    assign oldest[r*CW +: CW] = win[DEPTH-1];
    assign full[r]            = (cnt == NW'(DEPTH));

    // R5
    faw_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full[r] |-> ((now - win[DEPTH-1]) >= CW'(DEPTH)));
  end

endmodule

// File: rtl/ddr_cmd_gate.sv
`timescale 1ns/1ps
module ddr_cmd_gate
  import ddr_gate_pkg::*;
#(
  parameter int N_RANK  = 2,
  parameter int N_GROUP = 2,
  parameter int N_BANK  = 2,
  parameter int CW      = 32,
  parameter int FAW_N   = 4,
  parameter int BL      = 8,
  parameter int T_RC    = 12,
  parameter int T_RP    = 4,
  parameter int T_RTP   = 3,
  parameter int T_WL    = 4,
  parameter int T_RL    = 6,
  parameter int T_WR    = 5,
  parameter int T_RRD_L = 4,
  parameter int T_RRD_S = 2,
  parameter int T_RFC   = 20,
  parameter int T_FAW   = 16,
  parameter int T_RCD   = 4,
  parameter int T_CCD_L = 4,
  parameter int T_CCD_S = 2,
  parameter int T_WTR_L = 5,
  parameter int T_WTR_S = 2,
  parameter int T_RAS   = 9,
  localparam int RW = (N_RANK  > 1) ? $clog2(N_RANK)  : 1,
  localparam int GW = (N_GROUP > 1) ? $clog2(N_GROUP) : 1,
  localparam int BW = (N_BANK  > 1) ? $clog2(N_BANK)  : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    q_cmd,
  input  logic [RW-1:0] q_rank,
  input  logic [GW-1:0] q_group,
  input  logic [BW-1:0] q_bank,
  input  logic          rec_valid,
  input  logic [2:0]    rec_cmd,
  input  logic [RW-1:0] rec_rank,
  input  logic [GW-1:0] rec_group,
  input  logic [BW-1:0] rec_bank,
  output logic [CW-1:0] now_cycle,
  output logic [CW-1:0] earliest_cycle,
  output logic [CW-1:0] wait_cycles
);

  localparam int N_GALL  = N_RANK * N_GROUP;
  localparam int N_BALL  = N_GALL * N_BANK;
  localparam int GIW     = (N_GALL > 1) ? $clog2(N_GALL) : 1;
  localparam int BIW     = (N_BALL > 1) ? $clog2(N_BALL) : 1;
  localparam int BURST   = BL / 2;
  localparam int WR_REC  = T_WL + BURST + T_WR;
  localparam int RD2WR_R = T_RL + BURST + 2 - T_WL;
  localparam int RD2WR   = (RD2WR_R < 0) ? 0 : RD2WR_R;

  // slot kinds per level
  localparam int BK_ACT = 0, BK_PRE = 1, BK_RD = 2, BK_RDA = 3, BK_WR = 4, BK_WRA = 5, BK_REFB = 6;
  localparam int BK_N = 7;
  localparam int GR_ACT = 0, GR_RDX = 1, GR_WRX = 2, GR_N = 3;
  localparam int RK_ACT = 0, RK_REFA = 1, RK_N = 2;
  localparam int GL_RDX = 0, GL_WRX = 1, GL_ANY = 2, GL_N = 3;

  localparam logic [BK_N*8-1:0] BK_MASKS = {MSK_REFB, MSK_WRA, MSK_WR, MSK_RDA, MSK_RD, MSK_PRE, MSK_ACT};
  localparam logic [GR_N*8-1:0] GR_MASKS = {MSK_WRX, MSK_RDX, MSK_ACT};
  localparam logic [RK_N*8-1:0] RK_MASKS = {MSK_REFA, MSK_ACT};
  localparam logic [GL_N*8-1:0] GL_MASKS = {MSK_ANY, MSK_WRX, MSK_RDX};

  // free-running time base
  always_ff @(posedge clk) begin
    if (!rst_n) now_cycle <= '0;
    else        now_cycle <= now_cycle + 1'b1;
  end

  // flat location indices
  logic [BIW-1:0] qb, rb;
  logic [GIW-1:0] qg, rg;
  assign qb = BIW'((int'(q_rank) * N_GROUP + int'(q_group)) * N_BANK + int'(q_bank));
  assign rb = BIW'((int'(rec_rank) * N_GROUP + int'(rec_group)) * N_BANK + int'(rec_bank));
  assign qg = GIW'(int'(q_rank) * N_GROUP + int'(q_group));
  assign rg = GIW'(int'(rec_rank) * N_GROUP + int'(rec_group));

  logic [BK_N*N_BALL*CW-1:0] bk_st;
  logic [BK_N*N_BALL-1:0]    bk_vl;
  logic [GR_N*N_GALL*CW-1:0] gr_st;
  logic [GR_N*N_GALL-1:0]    gr_vl;
  logic [RK_N*N_RANK*CW-1:0] rk_st;
  logic [RK_N*N_RANK-1:0]    rk_vl;
  logic [GL_N*CW-1:0]        gl_st;
  logic [GL_N-1:0]           gl_vl;
  logic [N_RANK*CW-1:0]      faw_old;
  logic [N_RANK-1:0]         faw_full;

  gate_hist_level #(.CW(CW), .N_ENT(N_BALL), .N_KIND(BK_N), .IW(BIW), .MASKS(BK_MASKS)) u_bank_hist (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_idx(rb),
    .now(now_cycle), .stamps(bk_st), .vlds(bk_vl));

  gate_hist_level #(.CW(CW), .N_ENT(N_GALL), .N_KIND(GR_N), .IW(GIW), .MASKS(GR_MASKS)) u_group_hist (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_idx(rg),
    .now(now_cycle), .stamps(gr_st), .vlds(gr_vl));

  gate_hist_level #(.CW(CW), .N_ENT(N_RANK), .N_KIND(RK_N), .IW(RW), .MASKS(RK_MASKS)) u_rank_hist (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_idx(rec_rank),
    .now(now_cycle), .stamps(rk_st), .vlds(rk_vl));

  gate_hist_level #(.CW(CW), .N_ENT(1), .N_KIND(GL_N), .IW(1), .MASKS(GL_MASKS)) u_dev_hist (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_idx(1'b0),
    .now(now_cycle), .stamps(gl_st), .vlds(gl_vl));

  gate_act_window #(.CW(CW), .N_RANK(N_RANK), .DEPTH(FAW_N), .RW(RW)) u_act_window (
    .clk(clk), .rst_n(rst_n), .rec_act(rec_valid && rec_cmd == CMD_ACT), .rec_rank(rec_rank),
    .now(now_cycle), .oldest(faw_old), .full(faw_full));

  // history entries that belong to the candidate's location
  logic [CW-1:0] bs [BK_N];
  logic          bv [BK_N];
  logic [CW-1:0] gs [GR_N];
  logic          gv [GR_N];
  logic [CW-1:0] rs [RK_N];
  logic          rv [RK_N];
  logic [CW-1:0] xs [GL_N];
  logic          xv [GL_N];

  for (genvar k = 0; k < BK_N; k++) begin : g_bsel
    assign bs[k] = bk_st[(k*N_BALL + int'(qb))*CW +: CW];
    assign bv[k] = bk_vl[k*N_BALL + int'(qb)];
  end
  for (genvar k = 0; k < GR_N; k++) begin : g_gsel
    assign gs[k] = gr_st[(k*N_GALL + int'(qg))*CW +: CW];
    assign gv[k] = gr_vl[k*N_GALL + int'(qg)];
  end
  for (genvar k = 0; k < RK_N; k++) begin : g_rsel
    assign rs[k] = rk_st[(k*N_RANK + int'(q_rank))*CW +: CW];
    assign rv[k] = rk_vl[k*N_RANK + int'(q_rank)];
  end
  for (genvar k = 0; k < GL_N; k++) begin : g_xsel
    assign xs[k] = gl_st[k*CW +: CW];
    assign xv[k] = gl_vl[k];
  end

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] cur, input logic v,
                                         input logic [CW-1:0] s, input int t);
    logic [CW-1:0] c;
    c = s + CW'(t);
    return (v && c > cur) ? c : cur;
  endfunction

  always_comb begin
    logic [CW-1:0] e;
    e = now_cycle;
    case (q_cmd)
      CMD_ACT: begin
        e = bump(e, bv[BK_ACT],  bs[BK_ACT],  T_RC);
        e = bump(e, bv[BK_PRE],  bs[BK_PRE],  T_RP);
        e = bump(e, bv[BK_RDA],  bs[BK_RDA],  T_RTP + T_RP);
        e = bump(e, bv[BK_WRA],  bs[BK_WRA],  WR_REC + T_RP);
        e = bump(e, bv[BK_REFB], bs[BK_REFB], T_RFC);
        e = bump(e, gv[GR_ACT],  gs[GR_ACT],  T_RRD_L);
        e = bump(e, rv[RK_ACT],  rs[RK_ACT],  T_RRD_S);
        e = bump(e, rv[RK_REFA], rs[RK_REFA], T_RFC);
        e = bump(e, faw_full[q_rank], faw_old[int'(q_rank)*CW +: CW], T_FAW);
      end
      CMD_RD, CMD_RDA: begin
        e = bump(e, bv[BK_ACT], bs[BK_ACT], T_RCD);
        e = bump(e, gv[GR_RDX], gs[GR_RDX], T_CCD_L);
        e = bump(e, xv[GL_RDX], xs[GL_RDX], T_CCD_S);
        e = bump(e, gv[GR_WRX], gs[GR_WRX], T_WL + BURST + T_WTR_L);
        e = bump(e, xv[GL_WRX], xs[GL_WRX], T_WL + BURST + T_WTR_S);
      end
      CMD_WR, CMD_WRA: begin
        e = bump(e, bv[BK_ACT], bs[BK_ACT], T_RCD);
        e = bump(e, xv[GL_RDX], xs[GL_RDX], RD2WR);
        e = bump(e, gv[GR_WRX], gs[GR_WRX], T_CCD_L);
        e = bump(e, xv[GL_WRX], xs[GL_WRX], T_CCD_S);
      end
      CMD_PRE: begin
        e = bump(e, bv[BK_ACT], bs[BK_ACT], T_RAS);
        e = bump(e, bv[BK_RD],  bs[BK_RD],  T_RTP);
        e = bump(e, bv[BK_WR],  bs[BK_WR],  WR_REC);
      end
      default: ;
    endcase
    e = bump(e, xv[GL_ANY], xs[GL_ANY], 1);
    earliest_cycle = e;
  end

  assign wait_cycles = earliest_cycle - now_cycle;

  // R1
  not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    earliest_cycle >= now_cycle);

  // R1
  time_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (now_cycle == $past(now_cycle) + 1'b1));

  // R2
  act_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_cmd == CMD_ACT && q_cmd == CMD_ACT && rb == qb) |=>
      (!($stable(q_cmd) && $stable(qb)) || (earliest_cycle >= $past(now_cycle) + CW'(T_RC))));

endmodule

// File: tb/test_ddr_cmd_gate.sv
`timescale 1ns/1ps
module test_ddr_cmd_gate;

  localparam int C_ACT = 0, C_RD = 1, C_RDA = 2, C_WR = 3, C_WRA = 4, C_PRE = 5, C_REFA = 6, C_REFB = 7;
  // bench copies of the default timings (from the brief)
  localparam int TRC = 12, TRP = 4, TRTP = 3, TWL = 4, TRL = 6, BURST = 4, TWR = 5;
  localparam int TRRDL = 4, TRRDS = 2, TRFC = 20, TFAW = 16, TRCD = 4;
  localparam int TCCDL = 4, TCCDS = 2, TWTRL = 5, TWTRS = 2, TRAS = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  q_cmd = '0;
  logic        q_rank = 1'b0, q_group = 1'b0, q_bank = 1'b0;
  logic        rec_valid = 1'b0;
  logic [2:0]  rec_cmd = '0;
  logic        rec_rank = 1'b0, rec_group = 1'b0, rec_bank = 1'b0;
  logic [31:0] now_cycle, earliest_cycle, wait_cycles;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ddr_cmd_gate i_ddr_cmd_gate (
    .clk(clk), .rst_n(rst_n),
    .q_cmd(q_cmd), .q_rank(q_rank), .q_group(q_group), .q_bank(q_bank),
    .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_rank(rec_rank),
    .rec_group(rec_group), .rec_bank(rec_bank),
    .now_cycle(now_cycle), .earliest_cycle(earliest_cycle), .wait_cycles(wait_cycles));

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rec_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one record pulse for a full cycle; ts = cycle in which it issued
  task automatic rec(input int cmd, input int r, input int g, input int b, output int ts);
    rec_valid = 1'b1;
    rec_cmd = 3'(cmd); rec_rank = 1'(r); rec_group = 1'(g); rec_bank = 1'(b);
    #1 ts = int'(now_cycle);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic query(input string req, input int cmd, input int r, input int g, input int b, input int exp);
    q_cmd = 3'(cmd); q_rank = 1'(r); q_group = 1'(g); q_bank = 1'(b);
    #1;
    check(req, int'(earliest_cycle), mx(exp, int'(now_cycle)));
    check(req, int'(wait_cycles), int'(earliest_cycle) - int'(now_cycle));
  endtask

  task automatic t_reset();
    int t0;
    do_reset();
    check("R1 counter after reset", int'(now_cycle), 1);
    @(negedge clk);
    check("R1 counter tick", int'(now_cycle), 2);
    query("R10 empty history", C_ACT, 0, 0, 0, 0);
    rec(C_ACT, 0, 0, 0, t0);
    query("R2 act after act", C_ACT, 0, 0, 0, t0 + TRC);
    do_reset();
    query("R10 reset clears", C_ACT, 0, 0, 0, 0);
    query("R1 refresh query bus only", C_REFA, 1, 1, 1, 0);
  endtask

  task automatic t_act_bank();
    int t0, t1;
    do_reset();
    rec(C_ACT, 0, 0, 0, t0);
    repeat (9) @(negedge clk);
    rec(C_PRE, 0, 0, 0, t1);
    query("R2 act after pre", C_ACT, 0, 0, 0, mx(t0 + TRC, t1 + TRP));
    do_reset();
    rec(C_RDA, 1, 0, 1, t0);
    query("R2 act after rda", C_ACT, 1, 0, 1, t0 + TRTP + TRP);
    do_reset();
    rec(C_WRA, 1, 1, 0, t0);
    query("R2 act after wra", C_ACT, 1, 1, 0, t0 + TWL + BURST + TWR + TRP);
  endtask

  task automatic t_act_rank();
    int t0, t1;
    do_reset();
    rec(C_ACT, 0, 0, 0, t0);
    query("R3 same group rrd_l", C_ACT, 0, 0, 1, t0 + TRRDL);
    query("R3 other group rrd_s", C_ACT, 0, 1, 0, t0 + TRRDS);
    query("R3 other rank free", C_ACT, 1, 0, 0, t0 + 1);
    do_reset();
    rec(C_REFA, 0, 0, 0, t0);
    query("R4 after all-bank refresh", C_ACT, 0, 1, 1, t0 + TRFC);
    query("R4 refresh other rank", C_ACT, 1, 0, 0, t0 + 1);
    rec(C_REFB, 1, 1, 1, t1);
    query("R4 after bank refresh", C_ACT, 1, 1, 1, t1 + TRFC);
    query("R4 bank refresh other bank", C_ACT, 1, 1, 0, t1 + 1);
  endtask

  task automatic t_faw();
    int a0, a1, a2, a3, a4;
    do_reset();
    rec(C_ACT, 0, 0, 0, a0);
    rec(C_ACT, 0, 0, 1, a1);
    rec(C_ACT, 0, 1, 0, a2);
    query("R5 three acts no window", C_ACT, 0, 1, 1, mx(a2 + TRRDL, a2 + TRRDS));
    rec(C_ACT, 0, 1, 1, a3);
    query("R5 window from oldest", C_ACT, 0, 0, 0, mx(a0 + TFAW, a0 + TRC));
    query("R5 other rank unaffected", C_ACT, 1, 1, 1, a3 + 1);
    rec(C_ACT, 0, 0, 0, a4);
    query("R5 window slides", C_ACT, 0, 1, 1, mx(a1 + TFAW, mx(a3 + TRC, a4 + TRRDS)));
  endtask

  task automatic t_read();
    int t0, t1;
    do_reset();
    rec(C_ACT, 0, 0, 0, t0);
    query("R6 read after act", C_RD, 0, 0, 0, t0 + TRCD);
    rec(C_RD, 0, 0, 0, t1);
    query("R6 ccd_l same group", C_RD, 0, 0, 1, t1 + TCCDL);
    query("R6 ccd_s other group", C_RDA, 0, 1, 0, t1 + TCCDS);
    query("R6 ccd_s other rank", C_RDA, 1, 0, 0, t1 + TCCDS);
    do_reset();
    rec(C_WR, 0, 0, 0, t0);
    query("R7 wtr_l same group", C_RD, 0, 0, 1, t0 + TWL + BURST + TWTRL);
    query("R7 wtr_s other group", C_RD, 0, 1, 0, t0 + TWL + BURST + TWTRS);
    query("R7 wtr_s other rank", C_RDA, 1, 1, 1, t0 + TWL + BURST + TWTRS);
  endtask

  task automatic t_write();
    int t0, t1, t2;
    do_reset();
    rec(C_ACT, 0, 0, 0, t0);
    rec(C_RD, 0, 1, 0, t1);
    query("R8 read to write turn", C_WR, 0, 0, 0, mx(t0 + TRCD, t1 + TRL + BURST + 2 - TWL));
    repeat (10) @(negedge clk);
    rec(C_WRA, 0, 0, 1, t2);
    query("R8 ccd_l writes", C_WR, 0, 0, 1, t2 + TCCDL);
    query("R8 ccd_s writes", C_WRA, 1, 1, 1, t2 + TCCDS);
  endtask

  task automatic t_pre();
    int t0, t1, t2;
    do_reset();
    rec(C_ACT, 0, 0, 0, t0);
    query("R9 pre after act", C_PRE, 0, 0, 0, t0 + TRAS);
    repeat (7) @(negedge clk);
    rec(C_RD, 0, 0, 0, t1);
    query("R9 pre after read", C_PRE, 0, 0, 0, mx(t0 + TRAS, t1 + TRTP));
    rec(C_WR, 0, 0, 0, t2);
    query("R9 pre after write", C_PRE, 0, 0, 0, t2 + TWL + BURST + TWR);
    query("R9 other bank free", C_PRE, 0, 0, 1, t2 + 1);
  endtask

  task automatic t_same_cycle();
    int t0;
    do_reset();
    q_cmd = 3'(C_ACT); q_rank = 1'b1; q_group = 1'b0; q_bank = 1'b1;
    rec_valid = 1'b1;
    rec_cmd = 3'(C_ACT); rec_rank = 1'b1; rec_group = 1'b0; rec_bank = 1'b1;
    #1 t0 = int'(now_cycle);
    check("R11 same cycle old history", int'(earliest_cycle), t0);
    @(negedge clk);
    rec_valid = 1'b0;
    #1;
    check("R11 record visible next cycle", int'(earliest_cycle), t0 + TRC);
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_act_bank();
    t_act_rank();
    t_faw();
    t_read();
    t_write();
    t_pre();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule